// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves 8-bit characters in both directions over a single open-drain I/O line, in the half-duplex asynchronous style used on contact smart card links. It is paced by a bit-rate strobe (`tick`) from an external divider, with a fixed number of strobes per elementary time unit (ETU). It only pulls the line low and never drives it high. An external pull-up restores the high level. It can also produce the card clock.

Each character has a low start bit, eight data bits and an even parity bit. A guard time follows before the next start bit. The receiver checks parity. On a mismatch it pulls the line low for one ETU as an error signal and discards the byte. The transmitter looks for that error signal after each character. When it sees one, it repeats the same byte, up to a programmable number of times. Then it halts until the error flags are cleared. A convention select sets the bit order and polarity. A mode bit together with a two-bit clock field sets whether the card clock is stopped, running, or held at a fixed level.

Top module: `sc_xcvr`

## Requirements
- R1: A transmitted character is one low start bit, 8 data bits and one parity bit, each lasting OS_TICKS ticks. The parity bit makes the count of logical ones over data plus parity even. The next start bit of a queued byte follows the previous one by 12 ETU plus at most one tick when no error signal was seen.
- R2: With `cfg_inv`=0, data goes least significant bit first and line level equals bit value. With `cfg_inv`=1, data goes most significant bit first and every data and parity level is the inverse of its logical value. The receiver decodes using the same rule.
- R3: The receiver samples each bit near mid-ETU. A character with correct parity, arriving while `rx_full`=0, is placed on `rx_rdata` and sets `rx_full`. A one-cycle `rx_rd` pulse clears `rx_full`.
- R4: A received character with wrong parity sets `err_parity` and leaves `rx_full` and `rx_rdata` unchanged. The block pulls the line low from about 10.5 to 11.5 ETU after the start edge, then releases it, so the line is high again by 12 ETU.
- R5: A correct character that completes while `rx_full`=1 sets `err_overrun`, and `rx_rdata` keeps the earlier byte.
- R6: The transmitter samples the line about 11 ETU after its start bit. If the line is low there, it sets `err_signal` and sends the same byte again, starting 13 ETU after the previous start.
- R7: After `retry_max` repeats that all drew an error signal, transmission stops: no further start bit, `err_signal` stays set and `tx_end` stays low. A `flag_clr` pulse resumes operation for newly written bytes.
- R8: `tx_wr` loads a byte and clears `tx_empty`. `tx_empty` sets again when the byte moves into the shifter. `tx_end` clears when a character starts. `tx_end` sets only when a character is accepted without an error signal and no byte is queued.
- R9: With `cfg_mode`=0, `cfg_clk[0]`=0 holds `card_clk` low and `cfg_clk[0]`=1 makes it toggle on every tick. With `cfg_mode`=1, `cfg_clk[1]`=0 makes it toggle on every tick and `cfg_clk[1]`=1 holds it at the level of `cfg_clk[0]`.
- R10: After reset, `tx_empty`=1, `tx_end`=1, `rx_full`=0, all error flags are 0, `io_oe`=0 and `card_clk`=0 (with clock field 00, mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-rate strobe, OS_TICKS per ETU |
| io_in | input | 1 | Level of the shared I/O line |
| io_oe | output | 1 | Pull the I/O line low when 1 |
| card_clk | output | 1 | Card clock output |
| cfg_mode | input | 1 | Block-oriented clocking mode |
| cfg_inv | input | 1 | 0 direct, 1 inverse convention |
| cfg_clk | input | 2 | Card clock setting |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| retry_max | input | RETRY_W | Maximum number of repeats of one byte |
| tx_wr | input | 1 | Write strobe for transmit data |
| tx_wdata | input | 8 | Transmit data |
| tx_empty | output | 1 | Transmit data register empty |
| tx_end | output | 1 | Transmission ended |
| rx_rd | input | 1 | Read strobe, clears rx_full |
| rx_rdata | output | 8 | Received data |
| rx_full | output | 1 | Receive data register full |
| err_overrun | output | 1 | Overrun flag |
| err_signal | output | 1 | Error signal seen by transmitter |
| err_parity | output | 1 | Receive parity error |
| flag_clr | input | 1 | Clears error flags and releases a halted transmitter |

## Verification
On every cycle, the assertions check several relations. The transmitter and receiver never pull the line at the same time. The receiver drives its error pulse only with `err_parity` set. An overrun never alters the held byte. `tx_empty` falls only after a write, and `tx_end` rises only after an accepted character. The retry count stays within its limit, and a fixed card clock level matches its setting. Only the bench's scenarios can show the things a card model observes across the line. These include bit order and polarity under both conventions, parity, the placement of the error pulse, repetition of the same byte, the silence after the retry limit, and the start-to-start spacing of queued bytes.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GUARD, TX_HALT} tx_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_ERRSIG} rx_st_e;

  // ETU indices counted from the start bit (index 0)
  localparam logic [3:0] ETU_PAR     = 4'd9;   // parity bit slot
  localparam logic [3:0] ETU_DONE    = 4'd10;  // receiver verdict (mid-ETU)
  localparam logic [3:0] ETU_CHK     = 4'd11;  // error-signal sample / release
  localparam logic [3:0] ETU_ERR_END = 4'd12;  // last guard ETU after an error

  // Line level for a given ETU slot of an outgoing character
  function automatic logic tx_level(input logic [7:0] d, input logic [3:0] etu,
                                    input logic inv);
    logic b;
    logic lvl;
    b = 1'b1;
    if (etu == 4'd0) begin
      lvl = 1'b0;
    end else if (etu == ETU_PAR) begin
      b   = ^d;
      lvl = b ^ inv;
    end else if (etu < ETU_PAR) begin
      b   = inv ? d[3'(4'd8 - etu)] : d[3'(etu - 4'd1)];
      lvl = b ^ inv;
    end else begin
      lvl = 1'b1;
    end
    return lvl;
  endfunction

endpackage

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int OS_TICKS = 16,
  parameter int RETRY_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               line_in,
  input  logic               inv,
  input  logic               go,
  input  logic               clr,
  input  logic [7:0]         din,
  input  logic [RETRY_W-1:0] retry_max,
  output logic               oe,
  output logic               busy,
  output logic               take,
  output logic               ack,
  output logic               nak,
  output logic               halted
);

  localparam int PHW = $clog2(OS_TICKS);
  localparam logic [PHW-1:0] PH_LAST = PHW'(OS_TICKS - 1);

  tx_st_e             st_q, st_d;
  logic [PHW-1:0]     ph_q, ph_d;
  logic [3:0]         etu_q, etu_d;
  logic [7:0]         dat_q, dat_d;
  logic               err_q, err_d;
  logic [RETRY_W-1:0] rcnt_q, rcnt_d;
  logic               etu_end;

  assign etu_end = tick && (ph_q == PH_LAST);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    etu_d  = etu_q;
    dat_d  = dat_q;
    err_d  = err_q;
    rcnt_d = rcnt_q;
    take   = 1'b0;
    ack    = 1'b0;
    nak    = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (go && tick) begin
          take   = 1'b1;
          st_d   = TX_SEND;
          ph_d   = '0;
          etu_d  = '0;
          dat_d  = din;
          err_d  = 1'b0;
          rcnt_d = '0;
        end
      end
      TX_SEND, TX_GUARD: begin
        if (tick) begin
          if (etu_end) begin
            ph_d  = '0;
            etu_d = etu_q + 4'd1;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        if (st_q == TX_SEND) begin
          if (etu_end && etu_q == ETU_PAR) st_d = TX_GUARD;
        end else begin
          if (tick && ph_q == '0 && etu_q == ETU_CHK) begin
            if (!line_in) begin
              nak   = 1'b1;
              err_d = 1'b1;
            end else begin
              ack = 1'b1;
            end
          end
          if (etu_end && !err_q && etu_q == ETU_CHK) begin
            st_d = TX_IDLE;
          end else if (etu_end && err_q && etu_q == ETU_ERR_END) begin
            if (rcnt_q < retry_max) begin
              rcnt_d = rcnt_q + 1'b1;
              st_d   = TX_SEND;
              ph_d   = '0;
              etu_d  = '0;
              err_d  = 1'b0;
            end else begin
              st_d = TX_HALT;
            end
          end
        end
      end
      TX_HALT: begin
        if (clr) st_d = TX_IDLE;
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      ph_q   <= '0;
      etu_q  <= '0;
      dat_q  <= '0;
      err_q  <= 1'b0;
      rcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      etu_q  <= etu_d;
      dat_q  <= dat_d;
      err_q  <= err_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign oe     = (st_q == TX_SEND) && !tx_level(dat_q, etu_q, inv);
  assign busy   = (st_q == TX_SEND) || (st_q == TX_GUARD);
  assign halted = (st_q == TX_HALT);

  // R7: the repeat count never passes the programmed limit
  a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != TX_IDLE && $stable(retry_max)) |-> (rcnt_q <= retry_max));

  // R6: an observed error signal keeps the transmitter occupied (resend or halt)
  a_r6_nak_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nak |=> (busy || halted));

endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int OS_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic       en,
  input  logic       inv,
  output logic       oe,
  output logic       busy,
  output logic       done,
  output logic       par_ok,
  output logic [7:0] dout
);

  localparam int PHW = $clog2(OS_TICKS);
  localparam logic [PHW-1:0] PH_LAST = PHW'(OS_TICKS - 1);
  localparam logic [PHW-1:0] PH_MID  = PHW'(OS_TICKS / 2);

  rx_st_e         st_q, st_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [3:0]     etu_q, etu_d;
  logic [7:0]     sh_q, sh_d;
  logic           ok_q, ok_d;
  logic           prev_q;
  logic           mid;

  assign mid = tick && (ph_q == PH_MID);

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    etu_d = etu_q;
    sh_d  = sh_q;
    ok_d  = ok_q;
    done  = 1'b0;
    if (st_q == RX_IDLE) begin
      if (en && prev_q && !line_in) begin
        st_d  = RX_RECV;
        ph_d  = '0;
        etu_d = '0;
      end
    end else begin
      if (tick) begin
        if (ph_q == PH_LAST) begin
          ph_d  = '0;
          etu_d = etu_q + 4'd1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      if (mid) begin
        if (st_q == RX_RECV) begin
          if (etu_q == 4'd0) begin
            if (line_in) st_d = RX_IDLE;
          end else if (etu_q < ETU_PAR) begin
            sh_d = inv ? {sh_q[6:0], ~line_in} : {line_in, sh_q[7:1]};
          end else if (etu_q == ETU_PAR) begin
            ok_d = ((^sh_q) == (line_in ^ inv));
          end else begin
            done = 1'b1;
            st_d = ok_q ? RX_IDLE : RX_ERRSIG;
          end
        end else if (etu_q == ETU_CHK) begin
          st_d = RX_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      etu_q  <= '0;
      sh_q   <= '0;
      ok_q   <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      etu_q  <= etu_d;
      sh_q   <= sh_d;
      ok_q   <= ok_d;
      prev_q <= line_in;
    end
  end

  assign oe     = (st_q == RX_ERRSIG);
  assign busy   = (st_q != RX_IDLE);
  assign par_ok = ok_q;
  assign dout   = sh_q;

  // R4: a verdict of bad parity is followed by the error pulse
  a_r4_bad_par_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_ok) |=> oe);

  // R3: a good character never produces an error pulse
  a_r3_good_par_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && par_ok) |=> !oe);

endmodule

// File: rtl/sc_cardclk.sv
module sc_cardclk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode,
  input  logic [1:0] sel,
  output logic       clk_o
);

  logic run;
  logic lvl;
  logic q, d;

  assign run = mode ? !sel[1] : sel[0];
  assign lvl = mode & sel[1] & sel[0];

  always_comb begin
    if (!run)      d = lvl;
    else if (tick) d = ~q;
    else           d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  assign clk_o = q;

  // R9: in block mode with the hold setting the output follows the level bit
  a_r9_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && sel[1]) |=> (clk_o == $past(sel[0])));

  // R9: stopped clock in normal mode stays low
  a_r9_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !sel[0]) |=> !clk_o);

endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
  import sc_pkg::*;
#(
  parameter int OS_TICKS = 16,
  parameter int RETRY_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               io_in,
  output logic               io_oe,
  output logic               card_clk,
  input  logic               cfg_mode,
  input  logic               cfg_inv,
  input  logic [1:0]         cfg_clk,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               tx_wr,
  input  logic [7:0]         tx_wdata,
  output logic               tx_empty,
  output logic               tx_end,
  input  logic               rx_rd,
  output logic [7:0]         rx_rdata,
  output logic               rx_full,
  output logic               err_overrun,
  output logic               err_signal,
  output logic               err_parity,
  input  logic               flag_clr
);

  logic       sync1_q, sync2_q;
  logic [7:0] tdr_q, tdr_d, rdr_q, rdr_d;
  logic       tdre_q, tdre_d, tend_q, tend_d, rdrf_q, rdrf_d;
  logic       orer_q, orer_d, ers_q, ers_d, per_q, per_d;

  logic       tx_oe, tx_busy, tx_take, tx_ack, tx_nak, tx_halted;
  logic       rx_oe, rx_busy, rx_done, rx_par_ok;
  logic [7:0] rx_byte;
  logic       tx_go, rx_enable;

  // two-stage synchronizer on the shared line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= io_in;
      sync2_q <= sync1_q;
    end
  end

  // half duplex: each side waits while the other owns the line
  assign tx_go     = tx_en && !tdre_q && !rx_busy && !tx_halted;
  assign rx_enable = rx_en && !tx_busy;

  sc_tx #(.OS_TICKS(OS_TICKS), .RETRY_W(RETRY_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(sync2_q), .inv(cfg_inv),
    .go(tx_go), .clr(flag_clr), .din(tdr_q), .retry_max(retry_max),
    .oe(tx_oe), .busy(tx_busy), .take(tx_take), .ack(tx_ack), .nak(tx_nak),
    .halted(tx_halted)
  );

  sc_rx #(.OS_TICKS(OS_TICKS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(sync2_q), .en(rx_enable),
    .inv(cfg_inv), .oe(rx_oe), .busy(rx_busy), .done(rx_done),
    .par_ok(rx_par_ok), .dout(rx_byte)
  );

  sc_cardclk u_clk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(cfg_mode), .sel(cfg_clk),
    .clk_o(card_clk)
  );

  always_comb begin
    tdr_d  = tdr_q;
    tdre_d = tdre_q;
    tend_d = tend_q;
    rdr_d  = rdr_q;
    rdrf_d = rdrf_q;
    orer_d = orer_q;
    ers_d  = ers_q;
    per_d  = per_q;

    if (tx_take) tdre_d = 1'b1;
    if (tx_wr) begin
      tdr_d  = tx_wdata;
      tdre_d = 1'b0;
    end

    if (tx_take)                tend_d = 1'b0;
    else if (tx_ack && tdre_q)  tend_d = 1'b1;

    if (flag_clr) begin
      orer_d = 1'b0;
      ers_d  = 1'b0;
      per_d  = 1'b0;
    end
    if (rx_rd) rdrf_d = 1'b0;

    if (tx_nak) ers_d = 1'b1;
    if (rx_done) begin
      if (!rx_par_ok) begin
        per_d = 1'b1;
      end else if (rdrf_q) begin
        orer_d = 1'b1;
      end else begin
        rdr_d  = rx_byte;
        rdrf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr_q  <= '0;
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      orer_q <= 1'b0;
      ers_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      tdr_q  <= tdr_d;
      tdre_q <= tdre_d;
      tend_q <= tend_d;
      rdr_q  <= rdr_d;
      rdrf_q <= rdrf_d;
      orer_q <= orer_d;
      ers_q  <= ers_d;
      per_q  <= per_d;
    end
  end

  assign io_oe       = tx_oe | rx_oe;
  assign tx_empty    = tdre_q;
  assign tx_end      = tend_q;
  assign rx_rdata    = rdr_q;
  assign rx_full     = rdrf_q;
  assign err_overrun = orer_q;
  assign err_signal  = ers_q;
  assign err_parity  = per_q;

  // R1: the two sides never pull the line together
  a_r1_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_oe && rx_oe));

  // R4: the receiver's error pulse only starts with the parity flag raised
  a_r4_pulse_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_oe) |-> err_parity);

  // R5: an overrun leaves the held byte untouched
  a_r5_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_par_ok && rx_full) |=> $stable(rx_rdata));

  // R8: the empty flag drops only after a write
  a_r8_empty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(tx_wr));

  // R8: transmission end rises only after an accepted character
  a_r8_end_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> $past(tx_ack));

endmodule

// File: tb/tb_sc_xcvr.sv
`timescale 1ns/1ps
module tb_sc_xcvr;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       card_oe;
  logic       io_line;
  logic       io_oe, card_clk;
  logic       cfg_mode, cfg_inv;
  logic [1:0] cfg_clk;
  logic       tx_en, rx_en;
  logic [2:0] retry_max;
  logic       tx_wr;
  logic [7:0] tx_wdata;
  logic       tx_empty, tx_end, rx_rd, rx_full;
  logic [7:0] rx_rdata;
  logic       err_overrun, err_signal, err_parity, flag_clr;

  int n_chk = 0;
  int n_err = 0;
  int tcount = 0;
  logic [1:0] div = 2'd0;

  always #2.5 clk = ~clk;

  assign io_line = ~(io_oe | card_oe);

  sc_xcvr dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .io_in(io_line), .io_oe(io_oe),
    .card_clk(card_clk), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
    .cfg_clk(cfg_clk), .tx_en(tx_en), .rx_en(rx_en), .retry_max(retry_max),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty), .tx_end(tx_end),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full),
    .err_overrun(err_overrun), .err_signal(err_signal),
    .err_parity(err_parity), .flag_clr(flag_clr)
  );

  initial begin
    tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      tick = (div == 2'd3);
      div  = div + 2'd1;
      if (tick) tcount++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  task automatic pulse_wr(input logic [7:0] b);
    @(negedge clk); tx_wdata = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // card model sending one character; reports error signal and line recovery
  task automatic card_send(input logic [7:0] b, input logic inv, input logic badpar,
                           output logic nak_seen, output logic line_back);
    logic [9:0] lv;
    lv[0] = 1'b0;
    for (int k = 1; k <= 8; k++) lv[k] = (inv ? b[8-k] : b[k-1]) ^ inv;
    lv[9] = (^b) ^ badpar ^ inv;
    tk(1);
    for (int k = 0; k < 10; k++) begin
      card_oe = ~lv[k];
      tk(16);
    end
    card_oe = 1'b0;
    tk(16);
    nak_seen = ~io_line;
    tk(16);
    line_back = io_line;
    tk(16);
  endtask

  // card model receiving one character; optionally answers with an error signal
  task automatic card_recv(input logic inv, input logic nak, output logic [7:0] b,
                           output logic pok, output int t_start);
    logic lvl;
    logic plog;
    b = 8'h00;
    @(negedge clk);
    while (io_line) @(negedge clk);
    t_start = tcount;
    tk(8);
    for (int k = 1; k <= 9; k++) begin
      tk(16);
      lvl = io_line ^ inv;
      if (k <= 8) begin
        if (inv) b[8-k] = lvl;
        else     b[k-1] = lvl;
      end else begin
        plog = lvl;
      end
    end
    pok = ((^b) == plog);
    tk(16);
    if (nak) begin
      card_oe = 1'b1;
      tk(16);
      card_oe = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R10 tx_empty", tx_empty, 1);
    chk("R10 tx_end", tx_end, 1);
    chk("R10 rx_full", rx_full, 0);
    chk("R10 flags", {err_overrun, err_signal, err_parity}, 0);
    chk("R10 io_oe", io_oe, 0);
    chk("R10 card_clk", card_clk, 0);
  endtask

  task automatic t_tx_conv(input logic inv, input logic [7:0] b);
    logic [7:0] got; logic pok; int ts;
    cfg_inv = inv;
    pulse_wr(b);
    card_recv(inv, 1'b0, got, pok, ts);
    chk(inv ? "R2 tx inverse data" : "R1 tx direct data", got, b);
    chk("R1 tx parity even", pok, 1);
    tk(24);
    chk("R8 tx_end after accept", tx_end, 1);
    chk("R8 tx_empty after take", tx_empty, 1);
    chk("R6 no error signal", err_signal, 0);
    cfg_inv = 1'b0;
  endtask

  task automatic t_rx_paths();
    logic nk, lb;
    card_send(8'h5C, 1'b0, 1'b0, nk, lb);
    chk("R3 no error pulse", nk, 0);
    chk("R3 rx_full", rx_full, 1);
    chk("R3 rx_rdata", rx_rdata, 8'h5C);
    chk("R3 no parity err", err_parity, 0);
    card_send(8'h77, 1'b0, 1'b0, nk, lb);
    chk("R5 overrun flag", err_overrun, 1);
    chk("R5 byte kept", rx_rdata, 8'h5C);
    pulse_rd();
    chk("R3 read clears full", rx_full, 0);
    pulse_clr();
    card_send(8'h12, 1'b0, 1'b1, nk, lb);
    chk("R4 error pulse seen at 11 ETU", nk, 1);
    chk("R4 line released by 12 ETU", lb, 1);
    chk("R4 parity flag", err_parity, 1);
    chk("R4 byte not stored", rx_full, 0);
    pulse_clr();
    chk("R4 flag cleared", err_parity, 0);
    cfg_inv = 1'b1;
    card_send(8'hC3, 1'b1, 1'b0, nk, lb);
    chk("R2 rx inverse data", rx_rdata, 8'hC3);
    chk("R2 rx inverse no pulse", nk, 0);
    pulse_rd();
    cfg_inv = 1'b0;
  endtask

  task automatic t_retry();
    logic [7:0] got; logic pok; int ts;
    retry_max = 3'd3;
    pulse_wr(8'h96);
    card_recv(1'b0, 1'b1, got, pok, ts);
    chk("R6 first try data", got, 8'h96);
    tk(2);
    chk("R6 error signal flag", err_signal, 1);
    card_recv(1'b0, 1'b0, got, pok, ts);
    chk("R6 same byte resent", got, 8'h96);
    tk(24);
    chk("R8 tx_end after resent ok", tx_end, 1);
    pulse_clr();
  endtask

  task automatic t_cap();
    logic [7:0] got; logic pok; int ts; int edges;
    logic prev;
    retry_max = 3'd1;
    pulse_wr(8'h3C);
    card_recv(1'b0, 1'b1, got, pok, ts);
    card_recv(1'b0, 1'b1, got, pok, ts);
    chk("R7 last attempt same byte", got, 8'h3C);
    edges = 0;
    prev = io_line;
    for (int i = 0; i < 640; i++) begin
      tk(1);
      if (prev && !io_line) edges++;
      prev = io_line;
    end
    chk("R7 no further start bit", edges, 0);
    chk("R7 error flag kept", err_signal, 1);
    chk("R7 tx_end stays low", tx_end, 0);
    pulse_clr();
    pulse_wr(8'h41);
    card_recv(1'b0, 1'b0, got, pok, ts);
    chk("R7 resumes after clear", got, 8'h41);
    tk(24);
    retry_max = 3'd3;
  endtask

  task automatic t_b2b();
    logic [7:0] got; logic pok; int t1, t2;
    pulse_wr(8'h11);
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    pulse_wr(8'h22);
    card_recv(1'b0, 1'b0, got, pok, t1);
    chk("R1 first queued byte", got, 8'h11);
    tk(12);
    chk("R8 tx_end low with byte queued", tx_end, 0);
    card_recv(1'b0, 1'b0, got, pok, t2);
    chk("R1 second queued byte", got, 8'h22);
    chk("R1 start spacing 12 ETU", ((t2 - t1) >= 192) && ((t2 - t1) <= 196), 1);
    tk(24);
    chk("R8 tx_end after last", tx_end, 1);
  endtask

  task automatic count_toggles(input int n, output int t);
    logic p;
    t = 0;
    p = card_clk;
    for (int i = 0; i < n; i++) begin
      tk(1);
      if (card_clk != p) t++;
      p = card_clk;
    end
  endtask

  task automatic t_clk();
    int t;
    cfg_mode = 1'b0; cfg_clk = 2'b00; tk(2);
    count_toggles(20, t);
    chk("R9 mode0 off no toggles", t, 0);
    chk("R9 mode0 off low", card_clk, 0);
    cfg_clk = 2'b01; tk(2);
    count_toggles(20, t);
    chk("R9 mode0 running", t, 20);
    cfg_mode = 1'b1; cfg_clk = 2'b10; tk(2);
    chk("R9 mode1 fixed low", card_clk, 0);
    cfg_clk = 2'b11; tk(2);
    count_toggles(10, t);
    chk("R9 mode1 fixed high", card_clk, 1);
    chk("R9 mode1 fixed no toggles", t, 0);
    cfg_clk = 2'b00; tk(2);
    count_toggles(20, t);
    chk("R9 mode1 running", t, 20);
    cfg_mode = 1'b0; cfg_clk = 2'b00; tk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; card_oe = 1'b0;
    cfg_mode = 1'b0; cfg_inv = 1'b0; cfg_clk = 2'b00;
    tx_en = 1'b1; rx_en = 1'b1; retry_max = 3'd3;
    tx_wr = 1'b0; tx_wdata = 8'h00; rx_rd = 1'b0; flag_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_conv(1'b0, 8'hA5);
    t_tx_conv(1'b1, 8'h3B);
    t_rx_paths();
    t_retry();
    t_cap();
    t_b2b();
    t_clk();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule